// File: doc/BRIEF.md
# Sequential Multiply-Accumulate Unit

This block is an iterative 32x32 integer multiplier with an optional accumulate step. It performs four operations. Two are short: a multiply that keeps the low word of the product, and a multiply-accumulate that adds a 32-bit addend and keeps the low word. Two are long: a multiply that returns the full 64-bit product as a high and a low word, and a long multiply-accumulate that adds the product to a 64-bit high:low pair. The long forms treat the operands as unsigned or as two's-complement numbers, as the signedness input selects.

A client presents the operation, the signedness, both multiplicands and the addend, then raises `start_i` for one cycle while the unit is idle. The unit reads the second multiplicand one byte per cycle and stops as soon as the bytes it has not yet read carry no further information. Those bytes carry no information when they are all zeros, or when they are all ones and the operation is signed. A short operand therefore finishes sooner than a wide one. When the unit finishes it raises `done_o` for one cycle, with both result words and the negative and zero indications valid. The outputs hold these values until the next completion.

Top module: `mac_seq_unit`

## Requirements
- R1: With `op_i` = 0 (short multiply), `res_lo_o` is the low 32 bits of `a_i*b_i` and `res_hi_o` is 0, whatever `signed_i` is.
- R2: With `op_i` = 1 (short multiply-accumulate), `res_lo_o` is `(a_i*b_i + acc_i[31:0]) mod 2^32` and `res_hi_o` is 0.
- R3: With `op_i` = 2 (long multiply) and `signed_i` = 0, `{res_hi_o,res_lo_o}` is the full unsigned 64-bit product.
- R4: With `op_i` = 2 and `signed_i` = 1, both operands are sign-extended to 64 bits and `{res_hi_o,res_lo_o}` is the exact two's-complement product.
- R5: With `op_i` = 3 (long multiply-accumulate), `{res_hi_o,res_lo_o}` is `(product + acc_i) mod 2^64`, where `acc_i[63:32]` is the high word and the product is signed or unsigned per `signed_i`.
- R6: Let k be the smallest value in 1..4 for which `b_i` shifted right by 8k bits is zero, or is all ones when `signed_i` = 1 (an arithmetic shift in that case). Then `done_o` rises in the cycle k+1 cycles after the cycle in which `start_i` is accepted. The whole operation spans 2 to 5 cycles.
- R7: `busy_o` is high from the cycle after an accepted start up to the cycle before `done_o`. `done_o` lasts exactly one cycle, and `busy_o` is low while `done_o` is high.
- R8: A `start_i` raised while `busy_o` is high is ignored. It produces no extra `done_o`, and it does not change the latency or the result of the operation in flight.
- R9: At `done_o`, `neg_o` is the top bit of the result and `zero_o` is set when the result is zero. For short operations this is bit 31 and the low word. For long operations it is bit 63 and the full 64-bit value.
- R10: After reset `busy_o`, `done_o`, `neg_o`, `zero_o`, `res_lo_o` and `res_hi_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted only while idle |
| op_i | input | 2 | Operation: 0 short mul, 1 short mac, 2 long mul, 3 long mac |
| signed_i | input | 1 | Treat operands as two's complement |
| a_i | input | 32 | First multiplicand |
| b_i | input | 32 | Second multiplicand, consumed a byte per cycle |
| acc_i | input | 64 | Addend; only the low word is used by the short mac |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_lo_o | output | 32 | Low result word |
| res_hi_o | output | 32 | High result word |
| neg_o | output | 1 | Result is negative |
| zero_o | output | 1 | Result is zero |

## Verification
A corrupted partial sum or a misaligned shift of the first operand shows up as a wrong result word at the very `done_o` pulse of the affected operation. A wrong termination test shows up as a `done_o` pulse one or more cycles away from the cycle that the byte count of `b_i` predicts. A missing correction on an all-ones tail leaves an error of exactly the shifted multiplicand in the signed results. A control state that fails to return to idle shows up as a `done_o` that never comes, or as a start that is accepted twice.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_MAC  = 2'd1,
    OP_LMUL = 2'd2,
    OP_LMAC = 2'd3
  } mac_op_e;

  function automatic logic op_is_long(input mac_op_e op);
    return op[1];
  endfunction

  function automatic logic op_accumulates(input mac_op_e op);
    return op[0];
  endfunction
endpackage

// File: rtl/mac_operand_prep.sv
module mac_operand_prep #(
  parameter int DATA_W = 32,
  localparam int WIDE_W = 2 * DATA_W
) (
  input  mac_pkg::mac_op_e    op_i,
  input  logic                signed_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [WIDE_W-1:0]   acc_i,
  output logic [WIDE_W-1:0]   a_ext_o,
  output logic [WIDE_W-1:0]   acc_init_o
);
  always_comb begin
    if (signed_i) a_ext_o = {{DATA_W{a_i[DATA_W-1]}}, a_i};
    else          a_ext_o = {{DATA_W{1'b0}}, a_i};

    if (!mac_pkg::op_accumulates(op_i))
      acc_init_o = '0;
    else if (mac_pkg::op_is_long(op_i))
      acc_init_o = acc_i;
    else
      acc_init_o = {{DATA_W{1'b0}}, acc_i[DATA_W-1:0]};
  end
endmodule

// File: rtl/mac_chunk_step.sv
module mac_chunk_step #(
  parameter int DATA_W  = 32,
  parameter int CHUNK_W = 8,
  localparam int WIDE_W = 2 * DATA_W
) (
  input  logic [WIDE_W-1:0] acc_i,
  input  logic [WIDE_W-1:0] a_sh_i,
  input  logic [DATA_W-1:0] rem_i,
  input  logic              signed_i,
  output logic [WIDE_W-1:0] acc_o,
  output logic [WIDE_W-1:0] a_sh_o,
  output logic [DATA_W-1:0] rem_o,
  output logic              last_o
);
  logic [CHUNK_W-1:0]        chunk;
  logic [WIDE_W-1:0]         partial;
  logic [WIDE_W-1:0]         tail_fix;
  logic signed [DATA_W-1:0]  rem_ars;
  logic                      tail_ones;

  always_comb begin
    chunk     = rem_i[CHUNK_W-1:0];
    partial   = a_sh_i * WIDE_W'(chunk);
    rem_ars   = $signed(rem_i) >>> CHUNK_W;
    rem_o     = signed_i ? DATA_W'(rem_ars) : (rem_i >> CHUNK_W);
    tail_ones = signed_i && (rem_o == {DATA_W{1'b1}});
    a_sh_o    = a_sh_i << CHUNK_W;
    tail_fix  = tail_ones ? a_sh_o : '0;
    acc_o     = acc_i + partial - tail_fix;
    last_o    = (rem_o == '0) || tail_ones;
  end
endmodule

// File: rtl/mac_result_fmt.sv
module mac_result_fmt #(
  parameter int DATA_W = 32,
  localparam int WIDE_W = 2 * DATA_W
) (
  input  logic [WIDE_W-1:0] sum_i,
  input  logic              long_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o,
  output logic              neg_o,
  output logic              zero_o
);
  always_comb begin
    lo_o = sum_i[DATA_W-1:0];
    hi_o = long_i ? sum_i[WIDE_W-1:DATA_W] : '0;
    if (long_i) begin
      neg_o  = sum_i[WIDE_W-1];
      zero_o = (sum_i == '0);
    end else begin
      neg_o  = sum_i[DATA_W-1];
      zero_o = (sum_i[DATA_W-1:0] == '0);
    end
  end
endmodule

// File: rtl/mac_seq_unit.sv
module mac_seq_unit #(
  parameter int DATA_W  = 32,
  parameter int CHUNK_W = 8,
  localparam int WIDE_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [WIDE_W-1:0] acc_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] res_lo_o,
  output logic [DATA_W-1:0] res_hi_o,
  output logic              neg_o,
  output logic              zero_o
);
  import mac_pkg::*;

  mac_op_e           op_in;
  logic [WIDE_W-1:0] a_ext, acc_init;
  logic [WIDE_W-1:0] acc_q, a_sh_q;
  logic [DATA_W-1:0] rem_q;
  logic              sgn_q, long_q;
  logic [WIDE_W-1:0] acc_nx, a_sh_nx;
  logic [DATA_W-1:0] rem_nx;
  logic              last;
  logic [DATA_W-1:0] fmt_lo, fmt_hi;
  logic              fmt_neg, fmt_zero;

  assign op_in = mac_op_e'(op_i);

  mac_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .op_i(op_in), .signed_i(signed_i), .a_i(a_i), .acc_i(acc_i),
    .a_ext_o(a_ext), .acc_init_o(acc_init)
  );

  mac_chunk_step #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W)) u_step (
    .acc_i(acc_q), .a_sh_i(a_sh_q), .rem_i(rem_q), .signed_i(sgn_q),
    .acc_o(acc_nx), .a_sh_o(a_sh_nx), .rem_o(rem_nx), .last_o(last)
  );

  mac_result_fmt #(.DATA_W(DATA_W)) u_fmt (
    .sum_i(acc_nx), .long_i(long_q),
    .lo_o(fmt_lo), .hi_o(fmt_hi), .neg_o(fmt_neg), .zero_o(fmt_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      res_lo_o <= '0;
      res_hi_o <= '0;
      neg_o    <= 1'b0;
      zero_o   <= 1'b0;
      acc_q    <= '0;
      a_sh_q   <= '0;
      rem_q    <= '0;
      sgn_q    <= 1'b0;
      long_q   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          acc_q  <= acc_init;
          a_sh_q <= a_ext;
          rem_q  <= b_i;
          sgn_q  <= signed_i;
          long_q <= op_is_long(op_in);
        end
      end else begin
        acc_q  <= acc_nx;
        a_sh_q <= a_sh_nx;
        rem_q  <= rem_nx;
        if (last) begin
          busy_o   <= 1'b0;
          done_o   <= 1'b1;
          res_lo_o <= fmt_lo;
          res_hi_o <= fmt_hi;
          neg_o    <= fmt_neg;
          zero_o   <= fmt_zero;
        end
      end
    end
  end
endmodule

// File: rtl/mac_seq_checker.sv
module mac_seq_checker #(
  parameter int DATA_W    = 32,
  parameter int MAX_STEPS = 4,
  localparam int CNT_W    = $clog2(MAX_STEPS + 1) + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] res_lo_o,
  input logic [DATA_W-1:0] res_hi_o
);
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)         busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
    else             busy_cnt <= '0;
  end

  // R7: completion pulse is a single cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7: never busy and done together
  assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R7: a completion always follows a busy cycle
  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(busy_o));

  // R8: busy only begins from a start request
  assert_busy_needs_start_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  // R6: the run never exceeds the byte count of the operand
  assert_latency_bound_R6: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (busy_cnt < CNT_W'(MAX_STEPS)));

  // R9: results only move on a completion
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(res_lo_o) && $stable(res_hi_o)));
endmodule

bind mac_seq_unit mac_seq_checker #(.DATA_W(DATA_W), .MAX_STEPS(DATA_W / CHUNK_W)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .res_lo_o(res_lo_o), .res_hi_o(res_hi_o)
);

// File: tb/tb_mac_seq_unit.sv
module tb_mac_seq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        signed_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [63:0] acc_i = '0;
  logic        busy_o, done_o, neg_o, zero_o;
  logic [31:0] res_lo_o, res_hi_o;

  mac_seq_unit dut (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .signed_i(signed_i),
    .a_i(a_i), .b_i(b_i), .acc_i(acc_i), .busy_o(busy_o), .done_o(done_o),
    .res_lo_o(res_lo_o), .res_hi_o(res_hi_o), .neg_o(neg_o), .zero_o(zero_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] lo, hi;
    logic        n, z;
    int          lat, t0;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0, checks = 0, fails = 0, pushed = 0, dones = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic sg, input logic [31:0] a,
                        input logic [31:0] b, input logic [63:0] acc, input string tag);
    exp_t e;
    logic [63:0] ax, bx, prod, sum;
    int k;
    ax = sg ? {{32{a[31]}}, a} : {32'd0, a};
    bx = sg ? {{32{b[31]}}, b} : {32'd0, b};
    prod = ax * bx;
    case (op)
      2'd0: sum = {32'd0, prod[31:0]};
      2'd1: sum = {32'd0, prod[31:0] + acc[31:0]};
      2'd2: sum = prod;
      default: sum = prod + acc;
    endcase
    k = 4;
    for (int i = 4; i >= 1; i--) begin
      logic [31:0] r;
      r = sg ? 32'($signed(b) >>> (8 * i)) : (b >> (8 * i));
      if (r == 32'd0 || (sg && r == 32'hFFFF_FFFF)) k = i;
    end
    e.lo = sum[31:0];
    e.hi = sum[63:32];
    e.n  = op[1] ? sum[63] : sum[31];
    e.z  = op[1] ? (sum == 64'd0) : (sum[31:0] == 32'd0);
    e.lat = k + 1;
    e.tag = tag;
    while (busy_o) @(negedge clk);
    start_i = 1'b1; op_i = op; signed_i = sg; a_i = a; b_i = b; acc_i = acc;
    e.t0 = cyc;
    exp_q.push_back(e);
    pushed++;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && done_o) begin
      dones++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({res_hi_o, res_lo_o} == {e.hi, e.lo}, e.tag, "result",
              {res_hi_o, res_lo_o}, {e.hi, e.lo});
        check({neg_o, zero_o} == {e.n, e.z}, "R9", "flags n,z",
              64'({neg_o, zero_o}), 64'({e.n, e.z}));
        check((cyc - e.t0) == e.lat, "R6", "latency",
              64'(cyc - e.t0), 64'(e.lat));
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 64'(cyc), 64'(WATCHDOG));
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check({busy_o, done_o, neg_o, zero_o} == 4'b0, "R10", "reset controls",
          64'({busy_o, done_o, neg_o, zero_o}), 64'd0);
    check({res_hi_o, res_lo_o} == 64'd0, "R10", "reset results",
          {res_hi_o, res_lo_o}, 64'd0);

    run_op(2'd0, 1'b0, 32'd7, 32'd6, 64'd0, "R1");
    // R7: busy in the cycle after the accepted start
    check(busy_o === 1'b1, "R7", "busy after start", 64'(busy_o), 64'd1);
    run_op(2'd0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 64'd0, "R1");
    run_op(2'd0, 1'b1, 32'hF000_0001, 32'h8765_4321, 64'd0, "R1");
    run_op(2'd1, 1'b0, 32'd1000, 32'h0001_2345, 64'hDEAD_0000_FFFF_FF00, "R2");
    run_op(2'd1, 1'b1, 32'hFFFF_FFFF, 32'd5, 64'd5, "R2");
    run_op(2'd2, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, "R3");
    run_op(2'd2, 1'b0, 32'hABCD_0123, 32'h0000_1234, 64'd0, "R3");
    run_op(2'd2, 1'b0, 32'h0, 32'h0012_3456, 64'd0, "R3");
    run_op(2'd2, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, "R4");
    run_op(2'd2, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF, 64'd0, "R4");
    run_op(2'd2, 1'b1, 32'h0123_4567, 32'hFFFF_8000, 64'd0, "R4");
    run_op(2'd2, 1'b1, 32'h8000_0000, 32'h8000_0000, 64'd0, "R4");
    run_op(2'd3, 1'b1, 32'hFFFF_FFFE, 32'd3, 64'h0000_0000_0000_0006, "R5");
    run_op(2'd3, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R5");
    run_op(2'd3, 1'b1, 32'h7FFF_FFFF, 32'hFFF0_0000, 64'h1234_5678_9ABC_DEF0, "R5");

    // R8: a start during a long run is ignored
    run_op(2'd2, 1'b0, 32'h1111_1111, 32'h8000_0001, 64'd0, "R8");
    start_i = 1'b1; op_i = 2'd0; a_i = 32'd9; b_i = 32'd9; acc_i = '0;
    @(negedge clk);
    start_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check(dones == pushed, "R8", "done count", 64'(dones), 64'(pushed));
    check(busy_o == 1'b0, "R8", "idle after ignored start", 64'(busy_o), 64'd0);
    // R9: results hold after completion
    check({res_hi_o, res_lo_o} == 64'h1111_1111_9999_9999 * 64'd0 + (64'h1111_1111 * 64'h8000_0001),
          "R9", "held result", {res_hi_o, res_lo_o}, 64'h1111_1111 * 64'h8000_0001);
    summary();
  end
endmodule